// File: doc/BRIEF.md
# Display Coprocessor Power-Up Sequencer

This block brings an external display coprocessor out of power-down and leaves it showing a configured, cleared screen. After reset it toggles the coprocessor's active-low power-down pin, sends a fixed chain of host commands with millisecond gaps between them, and polls the identity register until the device answers. It then writes the panel timing, the pixel-clock set-up, the backlight PWM, the GPIO pins, a two-word start-up display list and the touch threshold. The pixel-clock divider is written after every other panel setting because that write turns the display on.

All bus traffic goes through a request/acknowledge port to a separate SPI access engine. Each request carries an operation code, a byte count, a 24-bit address and write data. The millisecond gaps come from a prescaler that divides the system clock by `CLK_PER_MS`. The register base, the display-list base, the panel timing values and the poll limit are parameters. The `bl_inv_i` strap selects the duty value for a backlight that is wired inverted.

Top module: `disp_pwrup_seq`

## Requirements
- R1: While `rst_ni` is low, `pd_no` is 1 and `req_o`, `ready_o` and `timeout_o` are 0.
- R2: After reset, `pd_no` stays low for 20 ms and then high for 20 ms before the first request is made. Each span may run up to 4 cycles longer. No request is made while `pd_no` is low.
- R3: The first four requests are host commands (`op_o`=0). Their command byte is in `addr_o[23:16]` and `addr_o[15:0]`=0. The byte values, in order, are 0x00 (wake), 0x44 (external oscillator), 0x62 (PLL 48 MHz) and 0x68 (core reset). The next request follows at least 20, 10 and 10 ms after the acknowledge of the first three, and at most 10 cycles beyond each gap. The request after core reset follows within 8 cycles.
- R4: After core reset the block repeats 1-byte reads (`op_o`=2, `size_o`=0) of `REG_BASE`+0x00 until `rdata_i` returns 0x7C. No write is issued before that match.
- R5: If `POLL_MAX` reads in a row return a value other than 0x7C, `timeout_o` goes high and stays high, and no further request is made. A match on read number `POLL_MAX` still succeeds.
- R6: The first writes are ten 2-byte writes (`op_o`=1, `size_o`=1) of the parameters H_CYCLE, H_OFFSET, H_SIZE, H_SYNC0, H_SYNC1, V_CYCLE, V_OFFSET, V_SIZE, V_SYNC0 and V_SYNC1. They go, in that order, to `REG_BASE`+0x20 and on in steps of 4 up to +0x44.
- R7: Next come four 1-byte writes: SWIZZLE to +0x50, PCLK_POL to +0x54, the value 1 to the spread register at +0x58, and last PCLK_DIV to +0x5C.
- R8: Next come two 2-byte writes to the PWM registers: frequency 1000 to +0x60, then duty to +0x64. The duty is 100 when `bl_inv_i`=0 and 0 when `bl_inv_i`=1.
- R9: Next the GPIO direction register at +0x70 is written with 0x82, then the GPIO register at +0x74 with 0x80, both 1-byte.
- R10: Next come 4-byte writes (`size_o`=2): 0x26000007 (clear all) to `DL_BASE`, 0x00000000 (display) to `DL_BASE`+4, then 1 to the list-swap register at `REG_BASE`+0x80.
- R11: The last write is 1200, 2 bytes, to `REG_BASE`+0x90. `ready_o` rises in the cycle after its acknowledge and then stays high with no further request.
- R12: Once `req_o` is raised it stays high, with `op_o`, `addr_o` and `wdata_o` unchanged, until the cycle in which `ack_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bl_inv_i | input | 1 | Backlight wired inverted: selects duty 0 instead of 100 |
| pd_no | output | 1 | Coprocessor power-down pin, active low |
| req_o | output | 1 | Bus request to the SPI engine |
| op_o | output | 2 | 0 host command, 1 write, 2 read |
| size_o | output | 2 | Byte count: 0 one, 1 two, 2 four |
| addr_o | output | 24 | Register address, or command byte in [23:16] |
| wdata_o | output | 32 | Write data, right-aligned |
| ack_i | input | 1 | One-cycle completion of the pending request |
| rdata_i | input | 8 | Read data, valid with `ack_i` |
| ready_o | output | 1 | Sequence finished |
| timeout_o | output | 1 | Identity poll gave up |

## Verification
The assertions assume that `ack_i` is a single-cycle pulse that arrives only while `req_o` is high, and that `rdata_i` is valid in that same cycle. They also assume that `bl_inv_i` is steady for the whole sequence. The responder in the bench acknowledges a fixed number of cycles after it sees a request and never acknowledges twice in a row. It drives read data only together with the acknowledge, and it changes the strap only while reset is held. The count of non-matching identity reads is set per run to cover a first-read match, a match on the last allowed read, and a poll that never matches.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;
  localparam int MS_W = 8;
  localparam int N_STEPS = 29;
  localparam int FIRST_WR = 7;
  localparam int IDX_W = $clog2(N_STEPS);

  typedef enum logic [2:0] {K_PD_LO, K_PD_HI, K_HOST, K_POLL, K_WRITE} step_kind_e;
  typedef enum logic [1:0] {BUS_CMD = 2'd0, BUS_WR = 2'd1, BUS_RD = 2'd2} bus_op_e;

  localparam logic [1:0] SZ_B1 = 2'd0;
  localparam logic [1:0] SZ_B2 = 2'd1;
  localparam logic [1:0] SZ_B4 = 2'd2;

  typedef struct packed {
    step_kind_e        kind;
    logic [1:0]        size;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [MS_W-1:0]   wait_ms;
  } step_t;

  localparam logic [7:0] HC_WAKE     = 8'h00;
  localparam logic [7:0] HC_XOSC     = 8'h44;
  localparam logic [7:0] HC_PLL48    = 8'h62;
  localparam logic [7:0] HC_CORE_RST = 8'h68;

  localparam logic [MS_W-1:0] MS_PD   = 8'd20;
  localparam logic [MS_W-1:0] MS_WAKE = 8'd20;
  localparam logic [MS_W-1:0] MS_CLK  = 8'd10;

  localparam int OFF_ID     = 'h00;
  localparam int OFF_TIM    = 'h20;
  localparam int OFF_SWZ    = 'h50;
  localparam int OFF_POL    = 'h54;
  localparam int OFF_SPREAD = 'h58;
  localparam int OFF_PCLK   = 'h5C;
  localparam int OFF_PWMF   = 'h60;
  localparam int OFF_PWMD   = 'h64;
  localparam int OFF_GDIR   = 'h70;
  localparam int OFF_GPIO   = 'h74;
  localparam int OFF_SWAP   = 'h80;
  localparam int OFF_TOUCH  = 'h90;

  localparam logic [7:0]  ID_VALUE  = 8'h7C;
  localparam logic [15:0] PWM_FREQ  = 16'd1000;
  localparam logic [15:0] PWM_DUTY  = 16'd100;
  localparam logic [7:0]  GDIR_VAL  = 8'h82;
  localparam logic [7:0]  GPIO_VAL  = 8'h80;
  localparam logic [31:0] DL_CLEAR  = 32'h2600_0007;
  localparam logic [31:0] DL_SHOW   = 32'h0000_0000;
  localparam logic [15:0] TOUCH_RZ  = 16'd1200;
endpackage

// File: rtl/pwrup_ms_timer.sv
module pwrup_ms_timer #(
  parameter int unsigned CLK_PER_MS = 100000,
  parameter int MS_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [MS_W-1:0] ms_i,
  output logic            done_o
);
  localparam int PW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [PW-1:0] PRE_TOP = PW'(CLK_PER_MS - 1);

  logic [PW-1:0]   pre_q;
  logic [MS_W-1:0] ms_q;
  logic            tick;

  assign tick   = (pre_q == '0);
  assign done_o = (ms_q == '0);

  // prescaler restarts on load so every delay is an exact multiple of a ms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= PRE_TOP;
      ms_q  <= '0;
    end else if (load_i) begin
      pre_q <= PRE_TOP;
      ms_q  <= ms_i;
    end else if (ms_q != '0) begin
      pre_q <= tick ? PRE_TOP : pre_q - 1'b1;
      if (tick) ms_q <= ms_q - 1'b1;
    end
  end

  p_busy_after_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && ms_i != '0 |=> !done_o);
  p_ms_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && ms_q != '0 |=> (ms_q == $past(ms_q)) || (ms_q == $past(ms_q) - 1'b1));
endmodule

// File: rtl/pwrup_step_rom.sv
module pwrup_step_rom import pwrup_pkg::*; #(
  parameter logic [ADDR_W-1:0] REG_BASE = 24'h302000,
  parameter logic [ADDR_W-1:0] DL_BASE  = 24'h000000,
  parameter logic [15:0] H_CYCLE  = 16'd548,
  parameter logic [15:0] H_OFFSET = 16'd43,
  parameter logic [15:0] H_SIZE   = 16'd480,
  parameter logic [15:0] H_SYNC0  = 16'd0,
  parameter logic [15:0] H_SYNC1  = 16'd41,
  parameter logic [15:0] V_CYCLE  = 16'd292,
  parameter logic [15:0] V_OFFSET = 16'd12,
  parameter logic [15:0] V_SIZE   = 16'd272,
  parameter logic [15:0] V_SYNC0  = 16'd0,
  parameter logic [15:0] V_SYNC1  = 16'd10,
  parameter logic [7:0]  SWIZZLE  = 8'd0,
  parameter logic [7:0]  PCLK_POL = 8'd1,
  parameter logic [7:0]  PCLK_DIV = 8'd5
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic             bl_inv_i,
  output step_t            step_o
);
  localparam logic [15:0] TIM [10] = '{H_CYCLE, H_OFFSET, H_SIZE, H_SYNC0, H_SYNC1,
                                        V_CYCLE, V_OFFSET, V_SIZE, V_SYNC0, V_SYNC1};

  function automatic logic [ADDR_W-1:0] reg_at(input int off);
    return REG_BASE + ADDR_W'(off);
  endfunction

  always_comb begin
    int unsigned w;
    logic [3:0]  ti;
    step_o      = '0;
    step_o.kind = K_WRITE;
    step_o.size = SZ_B1;
    w  = 0;
    ti = '0;
    case (idx_i)
      IDX_W'(0): begin step_o.kind = K_PD_LO; step_o.wait_ms = MS_PD; end
      IDX_W'(1): begin step_o.kind = K_PD_HI; step_o.wait_ms = MS_PD; end
      IDX_W'(2): begin step_o.kind = K_HOST; step_o.addr = {HC_WAKE, 16'h0};     step_o.wait_ms = MS_WAKE; end
      IDX_W'(3): begin step_o.kind = K_HOST; step_o.addr = {HC_XOSC, 16'h0};     step_o.wait_ms = MS_CLK; end
      IDX_W'(4): begin step_o.kind = K_HOST; step_o.addr = {HC_PLL48, 16'h0};    step_o.wait_ms = MS_CLK; end
      IDX_W'(5): begin step_o.kind = K_HOST; step_o.addr = {HC_CORE_RST, 16'h0}; end
      IDX_W'(6): begin step_o.kind = K_POLL; step_o.addr = reg_at(OFF_ID); end
      default: begin
        w  = int'(idx_i) - FIRST_WR;
        ti = 4'(w);
        if (w < 10) begin
          step_o.addr = reg_at(OFF_TIM + 4 * int'(w));
          step_o.data = 32'(TIM[ti]);
          step_o.size = SZ_B2;
        end else begin
          case (w)
            10: begin step_o.addr = reg_at(OFF_SWZ);    step_o.data = 32'(SWIZZLE); end
            11: begin step_o.addr = reg_at(OFF_POL);    step_o.data = 32'(PCLK_POL); end
            12: begin step_o.addr = reg_at(OFF_SPREAD); step_o.data = 32'd1; end
            13: begin step_o.addr = reg_at(OFF_PCLK);   step_o.data = 32'(PCLK_DIV); end
            14: begin step_o.addr = reg_at(OFF_PWMF);   step_o.data = 32'(PWM_FREQ); step_o.size = SZ_B2; end
            15: begin
              step_o.addr = reg_at(OFF_PWMD);
              step_o.data = bl_inv_i ? 32'd0 : 32'(PWM_DUTY);
              step_o.size = SZ_B2;
            end
            16: begin step_o.addr = reg_at(OFF_GDIR);   step_o.data = 32'(GDIR_VAL); end
            17: begin step_o.addr = reg_at(OFF_GPIO);   step_o.data = 32'(GPIO_VAL); end
            18: begin step_o.addr = DL_BASE;            step_o.data = DL_CLEAR; step_o.size = SZ_B4; end
            19: begin step_o.addr = DL_BASE + 24'd4;    step_o.data = DL_SHOW;  step_o.size = SZ_B4; end
            20: begin step_o.addr = reg_at(OFF_SWAP);   step_o.data = 32'd1;    step_o.size = SZ_B4; end
            default: begin step_o.addr = reg_at(OFF_TOUCH); step_o.data = 32'(TOUCH_RZ); step_o.size = SZ_B2; end
          endcase
        end
      end
    endcase
  end
endmodule

// File: rtl/disp_pwrup_seq.sv
module disp_pwrup_seq import pwrup_pkg::*; #(
  parameter int unsigned CLK_PER_MS = 100000,
  parameter int unsigned POLL_MAX   = 1000,
  parameter logic [ADDR_W-1:0] REG_BASE = 24'h302000,
  parameter logic [ADDR_W-1:0] DL_BASE  = 24'h000000,
  parameter logic [15:0] H_CYCLE  = 16'd548,
  parameter logic [15:0] H_OFFSET = 16'd43,
  parameter logic [15:0] H_SIZE   = 16'd480,
  parameter logic [15:0] H_SYNC0  = 16'd0,
  parameter logic [15:0] H_SYNC1  = 16'd41,
  parameter logic [15:0] V_CYCLE  = 16'd292,
  parameter logic [15:0] V_OFFSET = 16'd12,
  parameter logic [15:0] V_SIZE   = 16'd272,
  parameter logic [15:0] V_SYNC0  = 16'd0,
  parameter logic [15:0] V_SYNC1  = 16'd10,
  parameter logic [7:0]  SWIZZLE  = 8'd0,
  parameter logic [7:0]  PCLK_POL = 8'd1,
  parameter logic [7:0]  PCLK_DIV = 8'd5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bl_inv_i,
  output logic              pd_no,
  output logic              req_o,
  output logic [1:0]        op_o,
  output logic [1:0]        size_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic              ack_i,
  input  logic [7:0]        rdata_i,
  output logic              ready_o,
  output logic              timeout_o
);
  localparam int TW = $clog2(POLL_MAX + 1);
  localparam logic [TW-1:0] TRY_LAST = TW'(POLL_MAX - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_STEPS - 1);

  typedef enum logic [2:0] {ST_STEP, ST_BUS, ST_WAIT, ST_READY, ST_FAIL} st_e;

  st_e              st_q;
  logic [IDX_W-1:0] idx_q;
  logic [TW-1:0]    tries_q;
  logic             pd_q, id_ok_q;
  step_t            step;
  bus_op_e          bus_op;
  logic             tmr_load, tmr_done, last_step, pd_step;

  pwrup_step_rom #(
    .REG_BASE(REG_BASE), .DL_BASE(DL_BASE),
    .H_CYCLE(H_CYCLE), .H_OFFSET(H_OFFSET), .H_SIZE(H_SIZE), .H_SYNC0(H_SYNC0), .H_SYNC1(H_SYNC1),
    .V_CYCLE(V_CYCLE), .V_OFFSET(V_OFFSET), .V_SIZE(V_SIZE), .V_SYNC0(V_SYNC0), .V_SYNC1(V_SYNC1),
    .SWIZZLE(SWIZZLE), .PCLK_POL(PCLK_POL), .PCLK_DIV(PCLK_DIV)
  ) u_rom (
    .idx_i(idx_q), .bl_inv_i(bl_inv_i), .step_o(step)
  );

  pwrup_ms_timer #(.CLK_PER_MS(CLK_PER_MS), .MS_W(MS_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .ms_i(step.wait_ms), .done_o(tmr_done)
  );

  assign last_step = (idx_q == IDX_LAST);
  assign pd_step   = (step.kind == K_PD_LO) || (step.kind == K_PD_HI);
  assign tmr_load  = (st_q == ST_STEP && pd_step) ||
                     (st_q == ST_BUS && ack_i && step.kind != K_POLL && step.wait_ms != '0);

  always_comb begin
    case (step.kind)
      K_HOST:  bus_op = BUS_CMD;
      K_WRITE: bus_op = BUS_WR;
      default: bus_op = BUS_RD;
    endcase
  end

  assign req_o     = (st_q == ST_BUS);
  assign op_o      = bus_op;
  assign size_o    = step.size;
  assign addr_o    = step.addr;
  assign wdata_o   = step.data;
  assign pd_no     = pd_q;
  assign ready_o   = (st_q == ST_READY);
  assign timeout_o = (st_q == ST_FAIL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_STEP;
      idx_q   <= '0;
      tries_q <= '0;
      pd_q    <= 1'b1;
      id_ok_q <= 1'b0;
    end else begin
      case (st_q)
        ST_STEP: begin
          if (pd_step) begin
            pd_q <= (step.kind == K_PD_HI);
            st_q <= ST_WAIT;
          end else begin
            st_q <= ST_BUS;
          end
        end
        ST_BUS: if (ack_i) begin
          if (step.kind == K_POLL) begin
            if (rdata_i == ID_VALUE) begin
              id_ok_q <= 1'b1;
              idx_q   <= idx_q + 1'b1;
              st_q    <= ST_STEP;
            end else if (tries_q == TRY_LAST) begin
              st_q <= ST_FAIL;
            end else begin
              tries_q <= tries_q + 1'b1;
            end
          end else if (step.wait_ms != '0) begin
            st_q <= ST_WAIT;
          end else if (last_step) begin
            st_q <= ST_READY;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= ST_STEP;
          end
        end
        ST_WAIT: if (tmr_done) begin
          idx_q <= idx_q + 1'b1;
          st_q  <= ST_STEP;
        end
        default: st_q <= st_q;
      endcase
    end
  end

  p_hold_req_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(addr_o) && $stable(op_o) && $stable(wdata_o));
  p_pd_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_no |-> !req_o);
  p_no_early_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && op_o == BUS_WR |-> id_ok_q);
  p_fail_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> timeout_o && !req_o && !ready_o);
  p_ready_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o && !req_o && !timeout_o);
  p_one_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ready_o, timeout_o, req_o}));
endmodule

// File: tb/disp_pwrup_seq_tb.sv
module disp_pwrup_seq_tb;
  localparam int unsigned C = 10;
  localparam int unsigned TB_POLL = 6;
  localparam logic [23:0] RB = 24'h302000;
  localparam logic [23:0] DB = 24'h100000;
  localparam int LAT = 2;
  localparam int NW = 22;

  // {addr, data, size}
  localparam logic [57:0] EXP_TAB [NW] = '{
    {RB + 24'h20, 32'd548,  2'd1}, {RB + 24'h24, 32'd43,   2'd1},
    {RB + 24'h28, 32'd480,  2'd1}, {RB + 24'h2C, 32'd3,    2'd1},
    {RB + 24'h30, 32'd41,   2'd1}, {RB + 24'h34, 32'd292,  2'd1},
    {RB + 24'h38, 32'd12,   2'd1}, {RB + 24'h3C, 32'd272,  2'd1},
    {RB + 24'h40, 32'd2,    2'd1}, {RB + 24'h44, 32'd10,   2'd1},
    {RB + 24'h50, 32'd2,    2'd0}, {RB + 24'h54, 32'd1,    2'd0},
    {RB + 24'h58, 32'd1,    2'd0}, {RB + 24'h5C, 32'd5,    2'd0},
    {RB + 24'h60, 32'd1000, 2'd1}, {RB + 24'h64, 32'd100,  2'd1},
    {RB + 24'h70, 32'h82,   2'd0}, {RB + 24'h74, 32'h80,   2'd0},
    {DB,          32'h26000007, 2'd2}, {DB + 24'd4, 32'h0, 2'd2},
    {RB + 24'h80, 32'd1,    2'd2}, {RB + 24'h90, 32'd1200, 2'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0, bl_inv = 1'b0;
  logic pd_n, req, ack = 1'b0, ready, tmo;
  logic [1:0] op, sz;
  logic [23:0] addr;
  logic [31:0] wdata;
  logic [7:0] rdata = 8'h00;

  int cyc = 0, lat = 0, nread = 0, bad_reads = 0;
  int errors = 0, checks = 0;
  int n_log = 0, pd_fall = -1, pd_rise = -1, first_req = -1, ready_rise = -1, viol = 0;
  logic prev_pd = 1'b1, prev_req = 1'b0, prev_ack = 1'b0;
  logic [1:0] log_op [64];
  logic [1:0] log_sz [64];
  logic [23:0] log_addr [64];
  logic [31:0] log_data [64];
  int log_cyc [64];

  disp_pwrup_seq #(
    .CLK_PER_MS(C), .POLL_MAX(TB_POLL), .REG_BASE(RB), .DL_BASE(DB),
    .H_CYCLE(16'd548), .H_OFFSET(16'd43), .H_SIZE(16'd480), .H_SYNC0(16'd3), .H_SYNC1(16'd41),
    .V_CYCLE(16'd292), .V_OFFSET(16'd12), .V_SIZE(16'd272), .V_SYNC0(16'd2), .V_SYNC1(16'd10),
    .SWIZZLE(8'd2), .PCLK_POL(8'd1), .PCLK_DIV(8'd5)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bl_inv_i(bl_inv), .pd_no(pd_n), .req_o(req), .op_o(op),
    .size_o(sz), .addr_o(addr), .wdata_o(wdata), .ack_i(ack), .rdata_i(rdata),
    .ready_o(ready), .timeout_o(tmo)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // SPI engine model
  always @(posedge clk) begin
    if (req && !ack && lat == LAT) begin
      ack <= 1'b1;
      lat <= 0;
      if (op == 2'd2) begin
        rdata <= (nread < bad_reads) ? 8'h3C : 8'h7C;
        nread <= nread + 1;
      end
    end else begin
      ack <= 1'b0;
      lat <= (req && !ack) ? lat + 1 : 0;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (prev_pd && !pd_n) pd_fall = cyc;
    if (!prev_pd && pd_n) pd_rise = cyc;
    if (req && first_req < 0) first_req = cyc;
    if (ready && ready_rise < 0) ready_rise = cyc;
    if (prev_req && !prev_ack && !req) viol++;
    if (req && ack && n_log < 64) begin
      log_op[n_log] = op; log_sz[n_log] = sz; log_addr[n_log] = addr;
      log_data[n_log] = wdata; log_cyc[n_log] = cyc; n_log++;
    end
    prev_pd = pd_n; prev_req = req; prev_ack = ack;
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic string tag_of(input int w);
    if (w < 10) return "R6";
    if (w < 14) return "R7";
    if (w < 16) return "R8";
    if (w < 18) return "R9";
    if (w < 21) return "R10";
    return "R11";
  endfunction

  task automatic run(input int bad, input bit inv, input bit ok_exp);
    int n, base, hold, gaps[3];
    gaps = '{20, 10, 10};
    @(negedge clk);
    rst_n = 1'b0; bl_inv = inv; bad_reads = bad; nread = 0;
    n_log = 0; pd_fall = -1; pd_rise = -1; first_req = -1; ready_rise = -1; viol = 0;
    prev_pd = 1'b1; prev_req = 1'b0; prev_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk(pd_n == 1'b1, "R1 pd_no", pd_n, 1);
    chk(req == 1'b0 && ready == 1'b0 && tmo == 1'b0, "R1 req/ready/timeout", {req, ready, tmo}, 0);
    rst_n = 1'b1;
    n = 0;
    while (!ready && !tmo && n < 4000) begin @(negedge clk); n++; end
    chk(n < 4000, "R11 completion", n, 4000);
    hold = n_log;
    repeat (40) @(negedge clk);
    chk(n_log == hold && !req, "R11/R5 quiet after end", n_log, hold);
    chk(viol == 0, "R12 request held to ack", viol, 0);
    // R2 power cycle spans
    chk(pd_rise - pd_fall >= 20 * C && pd_rise - pd_fall <= 20 * C + 4, "R2 low span", pd_rise - pd_fall, 20 * C);
    chk(first_req - pd_rise >= 20 * C && first_req - pd_rise <= 20 * C + 4, "R2 high span", first_req - pd_rise, 20 * C);
    // R3 host commands
    for (int i = 0; i < 4; i++) begin
      logic [7:0] code;
      code = (i == 0) ? 8'h00 : (i == 1) ? 8'h44 : (i == 2) ? 8'h62 : 8'h68;
      chk(log_op[i] == 2'd0 && log_addr[i] == {code, 16'h0}, "R3 host command", log_addr[i], {code, 16'h0});
    end
    for (int i = 0; i < 3; i++)
      chk(log_cyc[i+1] - log_cyc[i] >= gaps[i] * C && log_cyc[i+1] - log_cyc[i] <= gaps[i] * C + 10,
          "R3 command gap", log_cyc[i+1] - log_cyc[i], gaps[i] * C);
    chk(log_cyc[4] - log_cyc[3] <= 8, "R3 poll follows core reset", log_cyc[4] - log_cyc[3], 8);
    if (!ok_exp) begin
      chk(tmo == 1'b1 && ready == 1'b0, "R5 timeout flag", {tmo, ready}, 2);
      chk(n_log == 4 + TB_POLL, "R5 read count", n_log, 4 + TB_POLL);
      for (int i = 4; i < n_log; i++)
        chk(log_op[i] == 2'd2, "R5 no write after timeout", log_op[i], 2);
    end else begin
      chk(n_log == 4 + bad + 1 + NW, "R4 transaction count", n_log, 4 + bad + 1 + NW);
      for (int i = 4; i < 5 + bad; i++)
        chk(log_op[i] == 2'd2 && log_sz[i] == 2'd0 && log_addr[i] == RB, "R4 id read", log_addr[i], RB);
      base = 5 + bad;
      for (int w = 0; w < NW; w++) begin
        logic [31:0] ed;
        ed = EXP_TAB[w][33:2];
        if (w == 15 && inv) ed = 32'd0;
        chk(log_op[base+w] == 2'd1 && log_addr[base+w] == EXP_TAB[w][57:34],
            $sformatf("%s write addr #%0d", tag_of(w), w), log_addr[base+w], EXP_TAB[w][57:34]);
        chk(log_data[base+w] == ed && log_sz[base+w] == EXP_TAB[w][1:0],
            $sformatf("%s write data #%0d", tag_of(w), w), log_data[base+w], ed);
      end
      chk(ready_rise == log_cyc[n_log-1] + 1, "R11 ready timing", ready_rise, log_cyc[n_log-1] + 1);
      chk(ready == 1'b1 && tmo == 1'b0, "R11 ready held", ready, 1);
    end
  endtask

  initial begin
    run(3, 1'b0, 1'b1);            // R4 a few misses
    run(0, 1'b1, 1'b1);            // R8 inverted backlight, first read matches
    run(TB_POLL - 1, 1'b0, 1'b1);  // R5 match on the last allowed read
    run(100, 1'b0, 1'b0);          // R5 never matches
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule